// File: doc/BRIEF.md
# Instruction Prefetch Queue with Deferred Bus Fault

The block runs ahead of the execution unit, requesting sequential 16-bit instruction words from the bus and buffering them in a small FIFO. Every buffered word carries a fault tag that records whether its bus cycle ended in a bus error. A fault does not trap at fetch time. The tag travels with the word, and the fault exception is raised only when the execution side takes that word.

Once a faulted word has been returned, the queue stops fetching, because the addresses after it cannot be trusted. A flush comes from a taken branch or a task switch. It empties the queue in one clock, drops every tag, and restarts fetching at a supplied target address. A faulted word that is flushed before it is taken therefore never raises an exception.

The bus side is a simple request/acknowledge pair. The request and address are held stable until a cycle with the acknowledge high. An acknowledge while the request is low is ignored. The consume side offers the oldest word with a valid flag and pops it on a take strobe.

Top module: `prefetch_queue`

## Requirements
- R1: After reset the queue is empty, `issue_valid_o` and `issue_fault_o` are low, `fetch_req_o` is high, and `fetch_addr_o` equals the parameter `RESET_ADDR`.
- R2: `fetch_req_o` is high whenever fewer than `DEPTH` words are buffered and no faulted word has been accepted since the last flush. A word is accepted on a clock where both `fetch_req_o` and `fetch_ack_i` are high. Each accepted word advances `fetch_addr_o` by 2. `fetch_ack_i` has no effect while `fetch_req_o` is low.
- R3: Words are delivered in fetch order. `issue_word_o` shows the oldest buffered word. A take with `issue_valid_o` high removes that word on that clock.
- R4: A word accepted with `fetch_berr_i` high is buffered like any other word and offered with `issue_valid_o` high. No exception is raised at fetch time.
- R5: After a faulted word is accepted, `fetch_req_o` stays low until the next flush.
- R6: Taking a faulted word raises `issue_fault_o` for exactly one clock, on the cycle after the take.
- R7: After that exception, `issue_valid_o` stays low until a flush, so further take strobes have no effect.
- R8: On a clock with `flush_i` high, all buffered words and tags are discarded. From the next cycle the queue is empty, `fetch_addr_o` equals `flush_addr_i`, and fetching resumes.
- R9: A word acknowledged on the same clock as a flush is discarded together with its fault tag, and fetching is not halted by it.
- R10: A take on the same clock as a flush is ignored, and `issue_fault_o` stays low on the following cycle.
- R11: A take while `issue_valid_o` is low changes nothing.
- R12: With `DEPTH` words buffered, `fetch_req_o` is low and no word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Discard all words and redirect fetching |
| flush_addr_i | input | ADDR_W | Fetch restart address used with flush |
| fetch_req_o | output | 1 | Bus fetch request |
| fetch_addr_o | output | ADDR_W | Byte address of the requested word |
| fetch_ack_i | input | 1 | Bus cycle completes this clock |
| fetch_word_i | input | 16 | Returned instruction word |
| fetch_berr_i | input | 1 | Returned word ended in a bus error |
| issue_valid_o | output | 1 | A word is available for the execution side |
| issue_word_o | output | 16 | Oldest buffered word |
| issue_take_i | input | 1 | Execution side takes the offered word |
| issue_fault_o | output | 1 | One-clock fault exception pulse |

## Verification
Two pairs of events can fall on the same clock: a flush with an acknowledged bus error, and a flush with a take of a faulted head word. Directed sequences place a bus error and a take on the exact clock of a flush. The randomized phase then mixes all four strobes freely. The bench judges each case with a reference queue model. It expects the flush to win in both pairs: no halt and no exception pulse on the next cycle, an empty queue, and fetching resumed at the target address.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  localparam int unsigned PFQ_WORD_W = 16;

  typedef logic [PFQ_WORD_W-1:0] pfq_word_t;

  typedef struct packed {
    logic      fault;
    pfq_word_t word;
  } pfq_entry_t;
endpackage

// File: rtl/pfq_fetch.sv
module pfq_fetch
  import pfq_pkg::*;
#(
  parameter int unsigned      ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  parameter int unsigned      ADDR_STEP  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] flush_addr_i,
  input  logic              space_i,
  input  logic              bus_ack_i,
  input  logic              bus_berr_i,
  input  pfq_word_t         bus_word_i,
  output logic              bus_req_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              push_o,
  output pfq_entry_t        push_entry_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(ADDR_STEP);

  logic              halted_q;
  logic [ADDR_W-1:0] addr_q;
  logic              accept;

  assign bus_req_o  = !halted_q && space_i;
  assign bus_addr_o = addr_q;
  assign accept     = bus_req_o && bus_ack_i;
  assign push_o     = accept && !flush_i;
  assign push_entry_o = '{fault: bus_berr_i, word: bus_word_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= RESET_ADDR;
      halted_q <= 1'b0;
    end else if (flush_i) begin
      addr_q   <= flush_addr_i;
      halted_q <= 1'b0;
    end else if (accept) begin
      addr_q <= addr_q + STEP;
      if (bus_berr_i) halted_q <= 1'b1;
    end
  end

  // R5
  halt_after_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && push_entry_o.fault) |=> !bus_req_o);

  // R8
  flush_redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (bus_addr_o == $past(flush_addr_i)));

  // R2
  addr_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && !accept) |=> $stable(bus_addr_o));
endmodule

// File: rtl/pfq_store.sv
module pfq_store
  import pfq_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       flush_i,
  input  logic       wr_en_i,
  input  pfq_entry_t wr_entry_i,
  input  logic       rd_en_i,
  output pfq_entry_t head_o,
  output logic       empty_o,
  output logic       space_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  pfq_entry_t       slot_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    slot_q[i] <= '0;
      else if (flush_i)                               slot_q[i] <= '0;
      else if (wr_en_i && wr_ptr_q == PTR_W'(i))      slot_q[i] <= wr_entry_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (wr_en_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (rd_en_i) rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({wr_en_i, rd_en_i})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign head_o  = slot_q[rd_ptr_q];
  assign empty_o = (count_q == '0);
  assign space_o = (count_q < FULL);

  // R3
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |-> (count_q != '0));

  // R12
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (count_q != FULL));

  // R8
  flush_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/pfq_issue.sv
module pfq_issue (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic take_i,
  input  logic empty_i,
  input  logic head_fault_i,
  output logic valid_o,
  output logic pop_o,
  output logic exc_o
);
  logic done_q, exc_q;

  assign valid_o = !empty_i && !done_q;
  assign pop_o   = take_i && valid_o && !flush_i;
  assign exc_o   = exc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      exc_q  <= 1'b0;
    end else if (flush_i) begin
      done_q <= 1'b0;
      exc_q  <= 1'b0;
    end else begin
      exc_q <= pop_o && head_fault_i;
      if (pop_o && head_fault_i) done_q <= 1'b1;
    end
  end

  // R6
  exc_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |=> !exc_o);

  // R7
  exc_blocks_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> !valid_o);

  // R10
  flush_no_exc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !exc_o);

  // R11
  idle_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !valid_o && !flush_i) |=> !exc_o);
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
  import pfq_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 32,
  parameter int unsigned       DEPTH      = 4,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] flush_addr_i,
  output logic              fetch_req_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  input  logic              fetch_ack_i,
  input  logic [15:0]       fetch_word_i,
  input  logic              fetch_berr_i,
  output logic              issue_valid_o,
  output logic [15:0]       issue_word_o,
  input  logic              issue_take_i,
  output logic              issue_fault_o
);
  logic       space, empty, push, pop;
  pfq_entry_t push_entry, head;

  pfq_fetch #(
    .ADDR_W    (ADDR_W),
    .RESET_ADDR(RESET_ADDR),
    .ADDR_STEP (PFQ_WORD_W / 8)
  ) u_fetch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .flush_addr_i(flush_addr_i),
    .space_i     (space),
    .bus_ack_i   (fetch_ack_i),
    .bus_berr_i  (fetch_berr_i),
    .bus_word_i  (fetch_word_i),
    .bus_req_o   (fetch_req_o),
    .bus_addr_o  (fetch_addr_o),
    .push_o      (push),
    .push_entry_o(push_entry)
  );

  pfq_store #(
    .DEPTH(DEPTH)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush_i),
    .wr_en_i   (push),
    .wr_entry_i(push_entry),
    .rd_en_i   (pop),
    .head_o    (head),
    .empty_o   (empty),
    .space_o   (space)
  );

  pfq_issue u_issue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .take_i      (issue_take_i),
    .empty_i     (empty),
    .head_fault_i(head.fault),
    .valid_o     (issue_valid_o),
    .pop_o       (pop),
    .exc_o       (issue_fault_o)
  );

  assign issue_word_o = head.word;

  // R4
  no_fetch_time_exc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty && !issue_fault_o) |=> !issue_fault_o);
endmodule

// File: tb/prefetch_queue_bench.sv
module prefetch_queue_bench;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DEPTH  = 4;
  localparam logic [31:0] RST_A  = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flush = 1'b0;
  logic [31:0] flush_addr = '0;
  logic        req;
  logic [31:0] addr;
  logic        ack = 1'b0;
  logic [15:0] fword = '0;
  logic        berr = 1'b0;
  logic        valid;
  logic [15:0] iword;
  logic        take = 1'b0;
  logic        fault;

  int checks = 0;
  int errors = 0;

  logic [16:0] mq[$];
  logic [31:0] m_addr;
  bit          m_halt, m_done, m_exc;

  always #2 clk = ~clk;

  prefetch_queue #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .RESET_ADDR(RST_A)) u_prefetch_queue (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush), .flush_addr_i(flush_addr),
    .fetch_req_o(req), .fetch_addr_o(addr), .fetch_ack_i(ack),
    .fetch_word_i(fword), .fetch_berr_i(berr),
    .issue_valid_o(valid), .issue_word_o(iword), .issue_take_i(take),
    .issue_fault_o(fault)
  );

  function automatic logic [15:0] mem_word(input logic [31:0] a);
    return a[16:1] ^ 16'h5A3C;
  endfunction

  function automatic bit exp_req();
    return !m_halt && (mq.size() < DEPTH);
  endfunction

  function automatic bit exp_valid();
    return (mq.size() != 0) && !m_done;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic check_all();
    check("R2 req", {31'b0, req}, {31'b0, exp_req()});
    check("R2 addr", addr, m_addr);
    check("R3 valid", {31'b0, valid}, {31'b0, exp_valid()});
    if (exp_valid()) check("R3 word", {16'b0, iword}, {16'b0, mq[0][15:0]});
    check("R6 exc", {31'b0, fault}, {31'b0, m_exc});
  endtask

  // drive one clock: check outputs, apply inputs, advance model, move to next negedge
  task automatic cycle(input bit f, input logic [31:0] fa, input bit a, input bit b, input bit t);
    bit acc, was_valid, nexc;
    check_all();
    flush = f; flush_addr = fa; ack = a; berr = b; take = t;
    fword = mem_word(m_addr);
    acc = exp_req() && a;
    was_valid = exp_valid();
    if (f) begin
      mq.delete(); m_addr = fa; m_halt = 0; m_done = 0; m_exc = 0;
    end else begin
      nexc = 0;
      if (t && was_valid) begin
        if (mq[0][16]) begin nexc = 1; m_done = 1; end
        void'(mq.pop_front());
      end
      if (acc) begin
        mq.push_back({b, fword});
        m_addr = m_addr + 2;
        if (b) m_halt = 1;
      end
      m_exc = nexc;
    end
    @(posedge clk);
    @(negedge clk);
    flush = 0; ack = 0; berr = 0; take = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_addr = RST_A; m_halt = 0; m_done = 0; m_exc = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 valid", {31'b0, valid}, 32'd0);
    check("R1 exc", {31'b0, fault}, 32'd0);
    check("R1 req", {31'b0, req}, 32'd1);
    check("R1 addr", addr, RST_A);

    // R12 fill to full, extra acks ignored
    repeat (6) cycle(0, 0, 1, 0, 0);
    check("R12 req low when full", {31'b0, req}, 32'd0);
    check("R12 addr held", addr, RST_A + 32'd8);
    // R3 drain in order
    repeat (4) cycle(0, 0, 0, 0, 1);
    check("R3 empty after drain", {31'b0, valid}, 32'd0);

    // R4/R5/R6/R7 fault taken
    cycle(1, 32'h1000, 0, 0, 0);
    cycle(0, 0, 1, 0, 0);
    cycle(0, 0, 1, 0, 0);
    cycle(0, 0, 1, 1, 0);
    check("R4 no exc at fetch", {31'b0, fault}, 32'd0);
    check("R4 faulted word buffered", {31'b0, valid}, 32'd1);
    repeat (3) cycle(0, 0, 1, 0, 0);
    check("R5 req held low", {31'b0, req}, 32'd0);
    check("R2 ack ignored w/o req", addr, 32'h1006);
    cycle(0, 0, 0, 0, 1);
    cycle(0, 0, 0, 0, 1);
    check("R4 no exc on clean take", {31'b0, fault}, 32'd0);
    cycle(0, 0, 0, 0, 1);
    check("R6 exc pulse", {31'b0, fault}, 32'd1);
    cycle(0, 0, 0, 0, 1);
    check("R6 exc one clock", {31'b0, fault}, 32'd0);
    check("R7 valid low after exc", {31'b0, valid}, 32'd0);
    repeat (2) cycle(0, 0, 1, 0, 1);
    check("R7 take ignored", {31'b0, fault}, 32'd0);

    // R8 flush drops faulted word before take
    cycle(1, 32'h2000, 0, 0, 0);
    cycle(0, 0, 1, 1, 0);
    cycle(1, 32'h3000, 0, 0, 0);
    check("R8 empty after flush", {31'b0, valid}, 32'd0);
    check("R8 redirect addr", addr, 32'h3000);
    check("R8 fetch resumed", {31'b0, req}, 32'd1);
    cycle(0, 0, 0, 0, 1);
    check("R8 no exc for flushed fault", {31'b0, fault}, 32'd0);

    // R9 berr on flush clock
    cycle(1, 32'h4000, 1, 1, 0);
    check("R9 not halted", {31'b0, req}, 32'd1);
    check("R9 word dropped", {31'b0, valid}, 32'd0);
    check("R9 addr target", addr, 32'h4000);

    // R10 take of faulted head on flush clock
    cycle(0, 0, 1, 1, 0);
    cycle(1, 32'h5000, 0, 0, 1);
    check("R10 no exc", {31'b0, fault}, 32'd0);
    check("R10 empty", {31'b0, valid}, 32'd0);

    // R11 take while empty
    cycle(0, 0, 0, 0, 1);
    check("R11 still empty", {31'b0, valid}, 32'd0);
    check("R11 no exc", {31'b0, fault}, 32'd0);
    check("R11 addr unchanged", addr, 32'h5000);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit f, a, b, t;
      logic [31:0] fa;
      f  = ($urandom_range(99) < 3);
      a  = ($urandom_range(99) < 60);
      b  = ($urandom_range(99) < 5);
      t  = ($urandom_range(99) < 50);
      fa = {16'h0, $urandom_range(16'hFFFF)} & 32'hFFFF_FFFE;
      cycle(f, fa, a, b, t);
    end
    check_all();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule